// File: doc/BRIEF.md
# Five-Level Stacked-Carrier Phase Modulator

This block turns three signed phase voltage references into five-level switching commands for a drive made of four two-level inverters per phase plus two bidirectional switches at the winding midpoint. It first centres the three references by subtracting the mean of their largest and smallest values, which makes better use of the dc bus in linear modulation. Each centred reference is then compared with four triangular carriers stacked one above another across the signed full-scale range, and the comparison gives a level from -2 to +2.

All four carriers come from one shared up/down counter, so they move in lock step. The centred references are captured only when the counter turns at a peak or valley. The level follows the comparison by at most one step per clock. A registered table converts each level into gate bits for the four inverter legs and the two bidirectional switches of that phase. The table uses redundant inverter states so that the two middle inverters and both bidirectional switches stay idle whenever the level is -1, 0 or +1. Dead time, protection and the speed-to-voltage law sit outside the block.

Top module: `pwm5_mod`

## Requirements
- R1: `car_cnt` traces a triangle 0,1,...,Q-1,Q-2,...,1,0,1,... where Q = 2^(REF_W-2). Each value is held for TICK_DIV clocks, and the counter reverses direction immediately at both ends.
- R2: While `rst_n` is low, `car_cnt` reads 0, `car_smp` is 0, every level is 0 and every gate output is 0. The first step after reset goes upward.
- R3: `car_smp` is high for exactly one clock: the last clock on which the counter holds Q-1 while rising, or 0 while falling. At reset the counter starts at 0 rising, and this start is not a turn.
- R4: At the clock edge that ends a `car_smp` cycle, each phase captures a shifted reference s = ref - floor((max+min)/2), where max and min are taken over the three present references. References at all other edges are ignored.
- R5: For each phase, the target level is -2 plus the number of carriers k (k = 0..3) for which s > cnt + (k-2)*Q. Here cnt is the present `car_cnt`.
- R6: Each `lvl_*` output is a signed 3-bit value in -2..+2. It starts at 0. At each clock edge it moves one step toward the target level computed before that edge, or holds if it already equals the target.
- R7: Each `gate_*` output is the encoding of the level output on the previous clock. Bit 0 is the leg of inverter 1, bit 1 inverter 2, bit 2 inverter 3, bit 3 inverter 4, and bits 5:4 are the two bidirectional switches. The encodings are: +2 gives 110011, +1 gives 000001, 0 gives 000000, -1 gives 001000, -2 gives 111100.
- R8: Both bidirectional switch bits are 0 whenever the level on the previous clock was -1, 0 or +1.
- R9: While every shifted reference stays within [-Q, Q], the levels stay within -1..+1, and the gate bits of inverters 2 and 3 and of both bidirectional switches stay 0.
- R10: The legs of inverter 1 and inverter 4 of a phase are never commanded on together. Inverter 1 is active only for positive levels and inverter 4 only for negative levels.
- R11: From one clock to the next, at most one of the four inverter leg bits of a phase changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_a | input | REF_W | Signed reference, phase a |
| ref_b | input | REF_W | Signed reference, phase b |
| ref_c | input | REF_W | Signed reference, phase c |
| car_cnt | output | REF_W-2 | Shared carrier counter value |
| car_smp | output | 1 | High on the clock before the counter turns at a peak or valley |
| lvl_a | output | 3 | Signed level of phase a (-2..+2) |
| lvl_b | output | 3 | Signed level of phase b (-2..+2) |
| lvl_c | output | 3 | Signed level of phase c (-2..+2) |
| gate_a | output | 6 | Leg and bidirectional switch commands, phase a |
| gate_b | output | 6 | Leg and bidirectional switch commands, phase b |
| gate_c | output | 6 | Leg and bidirectional switch commands, phase c |

## Verification
The hardest condition to create from the ports is a capture that makes the target level jump by several steps at once. Only then does the one-step slew limit act, and only then could a faulty table drive two inverter legs together. Ordinary sinusoids never produce such a jump, so the stimulus holds the references at opposite full-scale extremes and then reverses them. It also uses odd negative sums, to exercise the floor in the offset, and random holds of random length, so that references change between captures. A low-amplitude sinusoid run first after reset keeps every shifted reference inside the inner band, and across that whole window the middle inverters and the bidirectional switches must stay idle.

// File: rtl/pwm5_pkg.sv
// Shared types, counts and the level-to-gate encoding of the five-level modulator.
// Assumes three phases, four inverter legs and two midpoint switches per phase.
package pwm5_pkg;

    localparam int PHASES = 3;
    localparam int LEGS   = 4;
    localparam int BIDIRS = 2;
    localparam int GATE_W = LEGS + BIDIRS;

    // signed level, -2..+2
    typedef logic signed [2:0] lvl_t;

    localparam lvl_t LVL_HI = 3'sd2;
    localparam lvl_t LVL_LO = -3'sd2;

    // Gate word: [0] inv1, [1] inv2, [2] inv3, [3] inv4, [5:4] midpoint switches.
    // Redundant states chosen so inv2/inv3 and the switches act only at the outer levels.
    function automatic logic [GATE_W-1:0] level_gates(input lvl_t l);
        logic [GATE_W-1:0] g;
        case (l)
            3'b010:  g = 6'b11_0011;
            3'b001:  g = 6'b00_0001;
            3'b000:  g = 6'b00_0000;
            3'b111:  g = 6'b00_1000;
            3'b110:  g = 6'b11_1100;
            default: g = 6'b00_0000;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/pwm5_carrier.sv
// Shared triangular carrier: an up/down counter from 0 to all-ones, stepped once
// every TICK_DIV clocks. It flags the clock just before each turn (peak or valley).
// Assumes CNT_W >= 1 and TICK_DIV >= 1.
module pwm5_carrier #(
    parameter int CNT_W    = 10,
    parameter int TICK_DIV = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             smp
);

    localparam int               PRE_W    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
    localparam logic [CNT_W-1:0] TOP      = '1;

    logic [PRE_W-1:0] pre;
    logic             up;
    logic             tick;
    logic             at_end;

    // step enable and turn detection
    assign tick   = (pre == PRE_LAST);
    assign at_end = up ? (cnt == TOP) : (cnt == '0);
    assign smp    = tick & at_end;

    // prescaler and triangle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
            cnt <= '0;
            up  <= 1'b1;
        end else if (tick) begin
            pre <= '0;
            if (up) begin
                if (cnt == TOP) begin
                    up  <= 1'b0;
                    cnt <= cnt - 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                if (cnt == '0) begin
                    up  <= 1'b1;
                    cnt <= cnt + 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end else begin
            pre <= pre + 1'b1;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (({1'b0, cnt} == {1'b0, $past(cnt)} + (CNT_W+1)'(1)) ||
                                 ({1'b0, $past(cnt)} == {1'b0, cnt} + (CNT_W+1)'(1)))); // R1

    AST_SMP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        smp |-> ((cnt == '0) || (cnt == TOP))); // R3

    AST_SMP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        smp |=> !smp); // R3

endmodule

// File: rtl/pwm5_shift.sv
// Min-max offset injection: subtracts floor((max+min)/2) from every phase reference
// and holds the result between carrier turns. Assumes REF_W >= 3.
module pwm5_shift import pwm5_pkg::*; #(
    parameter int REF_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [PHASES-1:0][REF_W-1:0]  ref_in,
    input  logic                          smp,
    output logic [PHASES-1:0][REF_W:0]    sref
);

    localparam int SW = REF_W + 1;
    localparam logic signed [SW-1:0] LIM = SW'(2 ** (REF_W - 1));

    logic signed [SW-1:0] ext [PHASES];
    logic signed [SW-1:0] nxt [PHASES];
    logic signed [SW-1:0] mx;
    logic signed [SW-1:0] mn;
    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] half;

    // extremes, midpoint and shifted references
    always_comb begin
        for (int p = 0; p < PHASES; p++) begin
            ext[p] = SW'($signed(ref_in[p]));
        end
        mx = ext[0];
        mn = ext[0];
        for (int p = 1; p < PHASES; p++) begin
            if (ext[p] > mx) mx = ext[p];
            if (ext[p] < mn) mn = ext[p];
        end
        sum  = mx + mn;
        half = sum >>> 1;
        for (int p = 0; p < PHASES; p++) begin
            nxt[p] = ext[p] - half;
        end
    end

    // capture at carrier turns only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sref <= '0;
        end else if (smp) begin
            for (int p = 0; p < PHASES; p++) begin
                sref[p] <= nxt[p];
            end
        end
    end

    AST_SREF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp) |-> $stable(sref)); // R4

    generate
        for (genvar p = 0; p < PHASES; p++) begin : g_span
            AST_SREF_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
                ($signed(sref[p]) <= LIM) && ($signed(sref[p]) >= -LIM)); // R4
        end
    endgenerate

endmodule

// File: rtl/pwm5_level.sv
// One phase of the stacked-carrier comparator. Four carriers share the counter,
// offset by a quarter of full scale each. The level output steps at most once per
// clock toward the comparison result. Assumes REF_W >= 3.
module pwm5_level import pwm5_pkg::*; #(
    parameter int REF_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REF_W-3:0]     cnt,
    input  logic [REF_W:0]       sref,
    output lvl_t                 lvl
);

    localparam int CNT_W = REF_W - 2;
    localparam int SW    = REF_W + 1;
    localparam int Q     = 2 ** CNT_W;

    logic signed [SW-1:0] cnt_s;
    logic [LEGS-1:0]      above;
    logic [2:0]           n_above;
    logic signed [3:0]    raw4;
    lvl_t                 raw;

    assign cnt_s = $signed({{(SW-CNT_W){1'b0}}, cnt});

    // one comparator per stacked carrier
    generate
        for (genvar k = 0; k < LEGS; k++) begin : g_car
            localparam logic signed [SW-1:0] BASE = SW'((k - 2) * Q);
            assign above[k] = ($signed(sref) > (BASE + cnt_s));
        end
    endgenerate

    // target level from the number of carriers beaten
    always_comb begin
        n_above = 3'd0;
        for (int k = 0; k < LEGS; k++) begin
            n_above = n_above + {2'b00, above[k]};
        end
        raw4 = $signed({1'b0, n_above}) - 4'sd2;
        raw  = raw4[2:0];
    end

    // slew-limited level register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl <= '0;
        end else if (raw > lvl) begin
            lvl <= lvl + 3'sd1;
        end else if (raw < lvl) begin
            lvl <= lvl - 3'sd1;
        end
    end

    AST_LVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl <= LVL_HI) && (lvl >= LVL_LO)); // R6

    AST_LVL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == $past(lvl)) || (lvl == $past(lvl) + 3'sd1) || (lvl == $past(lvl) - 3'sd1)); // R6

endmodule

// File: rtl/pwm5_gate.sv
// Registered level-to-gate lookup for all phases. Assumes the levels arrive already
// limited to -2..+2.
module pwm5_gate import pwm5_pkg::*; (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [PHASES-1:0][2:0]        lvl,
    output logic [PHASES-1:0][GATE_W-1:0] gate
);

    // table lookup, one clock after the level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate <= '0;
        end else begin
            for (int p = 0; p < PHASES; p++) begin
                gate[p] <= level_gates(lvl_t'(lvl[p]));
            end
        end
    end

    generate
        for (genvar p = 0; p < PHASES; p++) begin : g_chk
            AST_BIDIR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                (gate[p][5:4] != 2'b00) |-> (($past(lvl[p]) == 3'b010) || ($past(lvl[p]) == 3'b110))); // R8

            AST_LEG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
                !(gate[p][0] && gate[p][3])); // R10

            AST_ONE_LEG: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(gate[p][3:0] ^ $past(gate[p][3:0])) <= 1); // R11
        end
    endgenerate

endmodule

// File: rtl/pwm5_mod.sv
// Top of the five-level stacked-carrier modulator: shared carrier, offset injection,
// per-phase comparators and the registered gate table. Assumes REF_W >= 3.
module pwm5_mod import pwm5_pkg::*; #(
    parameter int REF_W    = 12,
    parameter int TICK_DIV = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_a,
    input  logic signed [REF_W-1:0] ref_b,
    input  logic signed [REF_W-1:0] ref_c,
    output logic [REF_W-3:0]        car_cnt,
    output logic                    car_smp,
    output logic signed [2:0]       lvl_a,
    output logic signed [2:0]       lvl_b,
    output logic signed [2:0]       lvl_c,
    output logic [5:0]              gate_a,
    output logic [5:0]              gate_b,
    output logic [5:0]              gate_c
);

    localparam int CNT_W = REF_W - 2;

    logic [CNT_W-1:0]               cnt;
    logic                           smp;
    logic [PHASES-1:0][REF_W-1:0]   refs;
    logic [PHASES-1:0][REF_W:0]     sref;
    logic [PHASES-1:0][2:0]         lvl_all;
    logic [PHASES-1:0][GATE_W-1:0]  gates;

    assign refs = {ref_c, ref_b, ref_a};

    pwm5_carrier #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_car (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt),
        .smp   (smp)
    );

    pwm5_shift #(.REF_W(REF_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (refs),
        .smp    (smp),
        .sref   (sref)
    );

    generate
        for (genvar p = 0; p < PHASES; p++) begin : g_ph
            pwm5_level #(.REF_W(REF_W)) u_lvl (
                .clk   (clk),
                .rst_n (rst_n),
                .cnt   (cnt),
                .sref  (sref[p]),
                .lvl   (lvl_all[p])
            );
        end
    endgenerate

    pwm5_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl_all),
        .gate  (gates)
    );

    assign car_cnt = cnt;
    assign car_smp = smp;
    assign lvl_a   = lvl_all[0];
    assign lvl_b   = lvl_all[1];
    assign lvl_c   = lvl_all[2];
    assign gate_a  = gates[0];
    assign gate_b  = gates[1];
    assign gate_c  = gates[2];

endmodule

// File: tb/sim_pwm5_mod.sv
`timescale 1ns/1ps
// Bench for the five-level modulator: a behavioural model advanced at each rising
// edge, port checks at each falling edge, sinusoid, directed and random stimulus.
module sim_pwm5_mod;

    localparam int RW  = 10;
    localparam int TD  = 2;
    localparam int Q   = 256;
    localparam int TOP = Q - 1;

    logic clk = 1'b0;
    logic rst_n;
    logic signed [RW-1:0] ra, rb, rc;
    wire [RW-3:0] car_cnt;
    wire          car_smp;
    wire signed [2:0] la, lb, lc;
    wire [5:0] ga, gb, gc;

    always #2.5 clk = ~clk;

    pwm5_mod #(.REF_W(RW), .TICK_DIV(TD)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_a(ra), .ref_b(rb), .ref_c(rc),
        .car_cnt(car_cnt), .car_smp(car_smp),
        .lvl_a(la), .lvl_b(lb), .lvl_c(lc),
        .gate_a(ga), .gate_b(gb), .gate_c(gc)
    );

    int n_chk = 0;
    int n_err = 0;
    bit live = 0;
    bit low_win = 0;
    bit done = 0;

    // model state
    int m_pre, m_cnt, m_sref[3], m_lvl[3];
    bit m_up;
    logic [5:0] m_gate[3];
    int prev_lvl[3];
    logic [5:0] prev_gate[3];

    function automatic int floor_half(input int s);
        return (s >= 0) ? s / 2 : -((1 - s) / 2);
    endfunction

    function automatic int exp_raw(input int s, input int c);
        if (s > Q + c) return 2;
        else if (s > c) return 1;
        else if (s > c - Q) return 0;
        else if (s > c - 2 * Q) return -1;
        else return -2;
    endfunction

    function automatic logic [5:0] exp_gate(input int l);
        logic [5:0] g;
        g[0] = (l >= 1);
        g[1] = (l == 2);
        g[2] = (l == -2);
        g[3] = (l <= -1);
        g[5:4] = (l == 2 || l == -2) ? 2'b11 : 2'b00;
        return g;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, advanced at every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_up = 1;
            for (int p = 0; p < 3; p++) begin
                m_sref[p] = 0; m_lvl[p] = 0; m_gate[p] = 6'd0;
            end
        end else begin
            bit tk, sm;
            int r[3];
            int mx, mn, hf;
            tk = (m_pre == TD - 1);
            sm = tk && (m_up ? (m_cnt == TOP) : (m_cnt == 0));
            for (int p = 0; p < 3; p++) begin
                int tg;
                m_gate[p] = exp_gate(m_lvl[p]);
                tg = exp_raw(m_sref[p], m_cnt);
                if (tg > m_lvl[p]) m_lvl[p] = m_lvl[p] + 1;
                else if (tg < m_lvl[p]) m_lvl[p] = m_lvl[p] - 1;
            end
            if (sm) begin
                r[0] = int'(ra); r[1] = int'(rb); r[2] = int'(rc);
                mx = r[0]; mn = r[0];
                for (int p = 1; p < 3; p++) begin
                    if (r[p] > mx) mx = r[p];
                    if (r[p] < mn) mn = r[p];
                end
                hf = floor_half(mx + mn);
                for (int p = 0; p < 3; p++) m_sref[p] = r[p] - hf;
            end
            if (tk) begin
                m_pre = 0;
                if (m_up) begin
                    if (m_cnt == TOP) begin m_up = 0; m_cnt = TOP - 1; end
                    else m_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin m_up = 1; m_cnt = 1; end
                    else m_cnt = m_cnt - 1;
                end
            end else begin
                m_pre = m_pre + 1;
            end
        end
    end

    // port checks away from the active edge
    always @(negedge clk) begin
        if (live) begin
            int lo[3];
            logic [5:0] go[3];
            lo[0] = int'(la); lo[1] = int'(lb); lo[2] = int'(lc);
            go[0] = ga; go[1] = gb; go[2] = gc;
            if (!rst_n) begin
                check(car_cnt == 0, "R2 counter", int'(car_cnt), 0);
                check(car_smp == 1'b0, "R2 strobe", int'(car_smp), 0);
                for (int p = 0; p < 3; p++) begin
                    check(lo[p] == 0, "R2 level", lo[p], 0);
                    check(go[p] == 6'd0, "R2 gate", int'(go[p]), 0);
                    prev_lvl[p] = 0; prev_gate[p] = 6'd0;
                end
            end else begin
                bit es;
                es = (m_pre == TD - 1) && (m_up ? (m_cnt == TOP) : (m_cnt == 0));
                check(int'(car_cnt) == m_cnt, "R1 carrier", int'(car_cnt), m_cnt);
                check(car_smp == es, "R3 strobe", int'(car_smp), int'(es));
                for (int p = 0; p < 3; p++) begin
                    check(lo[p] == m_lvl[p], "R4 R5 R6 level", lo[p], m_lvl[p]);
                    check(go[p] == m_gate[p], "R7 gate map", int'(go[p]), int'(m_gate[p]));
                    if (prev_lvl[p] >= -1 && prev_lvl[p] <= 1)
                        check(go[p][5:4] == 2'b00, "R8 switches idle", int'(go[p][5:4]), 0);
                    check(!(go[p][0] && go[p][3]), "R10 leg exclusion", int'(go[p]), 0);
                    check($countones(go[p][3:0] ^ prev_gate[p][3:0]) <= 1, "R11 one leg",
                          $countones(go[p][3:0] ^ prev_gate[p][3:0]), 1);
                    if (low_win) begin
                        check(lo[p] >= -1 && lo[p] <= 1, "R9 inner level", lo[p], 0);
                        check(go[p][5:4] == 2'b00 && go[p][2:1] == 2'b00, "R9 idle middle",
                              int'(go[p]), 0);
                    end
                    prev_lvl[p] = lo[p];
                    prev_gate[p] = go[p];
                end
            end
        end
    end

    task automatic run_sine(input real amp, input int ncyc);
        real th;
        th = 0.0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (i % 64 == 0) begin
                th = th + 6.2831853 / 200.0;
                ra = RW'($rtoi(amp * $sin(th)));
                rb = RW'($rtoi(amp * $sin(th - 2.0943951)));
                rc = RW'($rtoi(amp * $sin(th + 2.0943951)));
            end
        end
    endtask

    task automatic hold3(input int a, input int b, input int c, input int ncyc);
        @(negedge clk);
        ra = RW'(a); rb = RW'(b); rc = RW'(c);
        repeat (ncyc) @(negedge clk);
    endtask

    task automatic run_rand(input int ncyc);
        int left;
        left = ncyc;
        while (left > 0) begin
            int hold;
            hold = 1 + int'($urandom % 700);
            @(negedge clk);
            ra = RW'($urandom); rb = RW'($urandom); rc = RW'($urandom);
            repeat (hold) @(negedge clk);
            left = left - hold;
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd7151));
        rst_n = 1'b0;
        ra = '0; rb = '0; rc = '0;
        @(negedge clk);
        @(negedge clk);
        live = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: low amplitude keeps every shifted reference in the inner band
        low_win = 1;
        run_sine(250.0, 15000);
        low_win = 0;
        // full range sinusoid reaching the outer levels
        run_sine(450.0, 20000);
        // directed corners: extremes, reversal (slew), odd negative sum, zero
        hold3(511, -512, 0, 2100);
        hold3(-512, 511, 0, 2100);
        hold3(-512, 511, 511, 2100);
        hold3(3, -6, 0, 2100);
        hold3(256, -128, -128, 2100);
        hold3(0, 0, 0, 2100);
        // random holds, references also change between strobes (R4)
        run_rand(25000);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end

endmodule